// File: doc/BRIEF.md
# Multi-Queue Ethernet DMA Control/Status Register Bank

This block is the word-addressed register bank in front of a multi-queue Ethernet DMA engine. A host writes and reads 32-bit words over a 4 KB window. Inside the bank, an event register collects notifications raised by the DMA logic. A mask register selects which of those notifications reach the three interrupt lines, one each for transmit, receive and error. A pair of per-queue halt status registers lets the host restart queues. Writing a 1 to a queue's status bit clears that bit and sends a one-cycle kick to the ring walker of that queue. On the receive side, a kick is sent only if the bit was not already set.

For each of eight transmit and eight receive rings, the bank holds a base register and a current-pointer register. Writing a base stores it with 8-byte alignment and reloads the matching current pointer in the same write. The current pointers are brought out as flat buses for the ring walkers. A few general registers show the three generic access behaviours: read-write, read-only and write-only. Descriptor walking, PHY management and the MAC datapath are outside this block.

Top module: `edma_csr`

## Requirements
- R1: After reset, every register reads zero except the control register (word 4, reset `0x0000_00C0`) and the identity register (word 5, constant `0x5EC0_0001`). All three interrupt outputs and both kick buses are low.
- R2: The event register (word 0) is write-one-to-clear. Each 1 written clears that bit. A bit raised on `evt_set` in the same cycle as a clearing write stays set.
- R3: The outputs are `irq_tx` = OR of (event AND mask) over bits 7:0, `irq_rx` = OR over bits 15:8, and `irq_err` = OR over bits 31:16. They follow the registers combinationally, so they change right after the edge that updates the event or mask register (word 1, read-write).
- R4: A write to the transmit status register (word 2) with bit 31−i set drives `tx_kick[i]` high for exactly the one cycle that follows the write edge. Each written bit is cleared from the register.
- R5: A write to the receive status register (word 3) with bit 23−i set drives `rx_kick[i]` for one cycle only when that bit was clear before the write. In either case, the written bits are cleared.
- R6: A write to transmit base n (word 64+n) or receive base n (word 80+n) stores the value with bits 2:0 forced to zero. The same value is copied into pointer n (words 72+n and 88+n), which appears on `tx_ring_ptr[32n+31:32n]` or `rx_ring_ptr[32n+31:32n]`.
- R7: The control register and the pointer registers take any written value unchanged. The identity register ignores writes.
- R8: The write-only register (word 6) always reads zero.
- R9: Words that are not mapped read zero, and writes to them change no register.
- R10: The word index is the byte address shifted right by two, so address bits 1:0 have no effect.
- R11: A pulse on `tx_qhalt_set[i]` or `rx_qhalt_set[i]` sets status bit 31−i or 23−i. A set in the same cycle as a clearing write wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| addr | input | 12 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| evt_set | input | 32 | Event raise pulses from the DMA logic |
| tx_qhalt_set | input | 8 | Per-queue transmit halt set pulses |
| rx_qhalt_set | input | 8 | Per-queue receive halt set pulses |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |
| tx_kick | output | 8 | One-cycle transmit ring kicks |
| rx_kick | output | 8 | One-cycle receive ring kicks |
| tx_ring_ptr | output | 256 | Transmit current pointers, queue n at bits 32n+31:32n |
| rx_ring_ptr | output | 256 | Receive current pointers, queue n at bits 32n+31:32n |

## Verification
The hardest cases to reach are the collisions between an internal set and a host clear in the same clock cycle. These are the event bit raised during its own W1C write, and the receive halt bit raised during its clearing write. The second one also decides whether the edge qualification suppresses a kick. The bench drives the set pulse and the write strobe on the same falling edge, so both land on one rising edge. It then reads back the register and watches the kick bus one cycle later. The other cases are covered by sweeps: every event bit against four mask patterns, every queue of both status registers with its bit clear and set, and every ring base with an unaligned value.

// File: rtl/edma_csr_pkg.sv
package edma_csr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;
  localparam int unsigned IW = AW - 2;
  localparam int unsigned NQ = 8;
  localparam int unsigned PTR_ALIGN_BITS = 3;

  localparam logic [DW-1:0] GRP_TX  = 32'h0000_00FF;
  localparam logic [DW-1:0] GRP_RX  = 32'h0000_FF00;
  localparam logic [DW-1:0] GRP_ERR = 32'hFFFF_0000;

  localparam int unsigned TXST_HI = 31;
  localparam int unsigned RXST_HI = 23;

  localparam int unsigned W_EVT    = 0;
  localparam int unsigned W_MASK   = 1;
  localparam int unsigned W_TXST   = 2;
  localparam int unsigned W_RXST   = 3;
  localparam int unsigned W_CTRL   = 4;
  localparam int unsigned W_IDENT  = 5;
  localparam int unsigned W_KEY    = 6;
  localparam int unsigned W_TXBASE = 64;
  localparam int unsigned W_TXPTR  = W_TXBASE + NQ;
  localparam int unsigned W_RXBASE = W_TXPTR + NQ;
  localparam int unsigned W_RXPTR  = W_RXBASE + NQ;

  localparam logic [DW-1:0] CTRL_RST  = 32'h0000_00C0;
  localparam logic [DW-1:0] IDENT_VAL = 32'h5EC0_0001;

  typedef enum logic [1:0] {
    ACC_RW = 2'd0,
    ACC_RO = 2'd1,
    ACC_WO = 2'd2
  } acc_e;

  // queue i sits at bit (hi - i) of a status word
  function automatic logic [NQ-1:0] queues_of(input logic [DW-1:0] w, input int unsigned hi);
    logic [NQ-1:0] q;
    for (int i = 0; i < NQ; i++) q[i] = w[hi-i];
    return q;
  endfunction

  function automatic logic [DW-1:0] word_of(input logic [NQ-1:0] q, input int unsigned hi);
    logic [DW-1:0] w;
    w = '0;
    for (int i = 0; i < NQ; i++) w[hi-i] = q[i];
    return w;
  endfunction

  function automatic logic [DW-1:0] align_ptr(input logic [DW-1:0] v);
    return {v[DW-1:PTR_ALIGN_BITS], {PTR_ALIGN_BITS{1'b0}}};
  endfunction

  function automatic logic group_hit(input logic [DW-1:0] evt, input logic [DW-1:0] msk,
                                     input logic [DW-1:0] grp);
    return |(evt & msk & grp);
  endfunction
endpackage

// File: rtl/edma_evt_irq.sv
module edma_evt_irq
  import edma_csr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_we,
  input  logic          mask_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt_set,
  output logic [DW-1:0] evt_q,
  output logic [DW-1:0] mask_q,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          irq_err
);
  logic [DW-1:0] evt_clr;

  assign evt_clr = evt_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q <= (evt_q & ~evt_clr) | evt_set;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign irq_tx  = group_hit(evt_q, mask_q, GRP_TX);
  assign irq_rx  = group_hit(evt_q, mask_q, GRP_RX);
  assign irq_err = group_hit(evt_q, mask_q, GRP_ERR);

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((evt_q & $past(evt_set)) == $past(evt_set))); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_we |=> ((evt_q & $past(wdata) & ~$past(evt_set)) == '0)); // R2
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !(irq_tx || irq_rx || irq_err)); // R3
endmodule

// File: rtl/edma_qstat.sv
module edma_qstat
  import edma_csr_pkg::*;
#(
  parameter int unsigned HI      = 31,
  parameter bit          RX_EDGE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic [NQ-1:0] set_q,
  output logic [NQ-1:0] kick,
  output logic [DW-1:0] rd_word
);
  logic [NQ-1:0] st;
  logic [NQ-1:0] wsel;
  logic [NQ-1:0] fire;

  assign wsel = we ? queues_of(wdata, HI) : '0;

  generate
    if (RX_EDGE) begin : g_edge
      assign fire = wsel & ~st;
    end else begin : g_level
      assign fire = wsel;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= '0;
      kick <= '0;
    end else begin
      st   <= (st & ~wsel) | set_q;
      kick <= fire;
    end
  end

  assign rd_word = word_of(st, HI);

  AST_KICK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (kick != '0) |-> $past(we)); // R4
  AST_STAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((st & $past(queues_of(wdata, HI)) & ~$past(set_q)) == '0)); // R4
  AST_SET_WINS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q != '0) |=> ((st & $past(set_q)) == $past(set_q))); // R11

  generate
    if (RX_EDGE) begin : g_edge_chk
      AST_RX_NO_REKICK: assert property (@(posedge clk) disable iff (!rst_n)
        ((kick & $past(st)) == '0)); // R5
    end
  endgenerate
endmodule

// File: rtl/edma_ring_bank.sv
module edma_ring_bank
  import edma_csr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] base_we,
  input  logic [NQ-1:0] ptr_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] base_q [NQ],
  output logic [DW-1:0] ptr_q  [NQ]
);
  generate
    for (genvar n = 0; n < NQ; n++) begin : g_ring
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          base_q[n] <= '0;
          ptr_q[n]  <= '0;
        end else if (base_we[n]) begin
          base_q[n] <= align_ptr(wdata);
          ptr_q[n]  <= align_ptr(wdata);
        end else if (ptr_we[n]) begin
          ptr_q[n]  <= wdata;
        end
      end

      AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (base_q[n][PTR_ALIGN_BITS-1:0] == '0)); // R6
      AST_PTR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        base_we[n] |=> (ptr_q[n] == base_q[n])); // R6
    end
  endgenerate
endmodule

// File: rtl/edma_gen_reg.sv
module edma_gen_reg
  import edma_csr_pkg::*;
#(
  parameter acc_e          ACC = ACC_RW,
  parameter logic [DW-1:0] RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_word
);
  logic [DW-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST;
    else if (we && (ACC != ACC_RO)) q <= wdata;
  end

  assign rd_word = (ACC == ACC_WO) ? '0 : q;

  generate
    if (ACC == ACC_RO) begin : g_ro_chk
      AST_RO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(rd_word)); // R7
    end
  endgenerate
endmodule

// File: rtl/edma_csr.sv
module edma_csr
  import edma_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     evt_set,
  input  logic [NQ-1:0]     tx_qhalt_set,
  input  logic [NQ-1:0]     rx_qhalt_set,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err,
  output logic [NQ-1:0]     tx_kick,
  output logic [NQ-1:0]     rx_kick,
  output logic [NQ*DW-1:0]  tx_ring_ptr,
  output logic [NQ*DW-1:0]  rx_ring_ptr
);
  logic [IW-1:0] idx;
  logic          we_evt, we_mask, we_txst, we_rxst, we_ctrl, we_ident, we_key;
  logic [NQ-1:0] we_txbase, we_txptr, we_rxbase, we_rxptr;
  logic [DW-1:0] evt_q, mask_q, txst_rd, rxst_rd, ctrl_rd, ident_rd, key_rd;
  logic [DW-1:0] txbase_q [NQ];
  logic [DW-1:0] txptr_q  [NQ];
  logic [DW-1:0] rxbase_q [NQ];
  logic [DW-1:0] rxptr_q  [NQ];

  assign idx = IW'(addr >> 2);

  // write decode: one strobe per word
  assign we_evt   = wr_en && (idx == IW'(W_EVT));
  assign we_mask  = wr_en && (idx == IW'(W_MASK));
  assign we_txst  = wr_en && (idx == IW'(W_TXST));
  assign we_rxst  = wr_en && (idx == IW'(W_RXST));
  assign we_ctrl  = wr_en && (idx == IW'(W_CTRL));
  assign we_ident = wr_en && (idx == IW'(W_IDENT));
  assign we_key   = wr_en && (idx == IW'(W_KEY));

  generate
    for (genvar n = 0; n < NQ; n++) begin : g_dec
      assign we_txbase[n] = wr_en && (idx == IW'(W_TXBASE + n));
      assign we_txptr[n]  = wr_en && (idx == IW'(W_TXPTR + n));
      assign we_rxbase[n] = wr_en && (idx == IW'(W_RXBASE + n));
      assign we_rxptr[n]  = wr_en && (idx == IW'(W_RXPTR + n));
      assign tx_ring_ptr[n*DW +: DW] = txptr_q[n];
      assign rx_ring_ptr[n*DW +: DW] = rxptr_q[n];
    end
  endgenerate

  edma_evt_irq u_evt (
    .clk(clk), .rst_n(rst_n), .evt_we(we_evt), .mask_we(we_mask), .wdata(wdata),
    .evt_set(evt_set), .evt_q(evt_q), .mask_q(mask_q),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  edma_qstat #(.HI(TXST_HI), .RX_EDGE(1'b0)) u_txst (
    .clk(clk), .rst_n(rst_n), .we(we_txst), .wdata(wdata),
    .set_q(tx_qhalt_set), .kick(tx_kick), .rd_word(txst_rd)
  );

  edma_qstat #(.HI(RXST_HI), .RX_EDGE(1'b1)) u_rxst (
    .clk(clk), .rst_n(rst_n), .we(we_rxst), .wdata(wdata),
    .set_q(rx_qhalt_set), .kick(rx_kick), .rd_word(rxst_rd)
  );

  edma_ring_bank u_txring (
    .clk(clk), .rst_n(rst_n), .base_we(we_txbase), .ptr_we(we_txptr),
    .wdata(wdata), .base_q(txbase_q), .ptr_q(txptr_q)
  );

  edma_ring_bank u_rxring (
    .clk(clk), .rst_n(rst_n), .base_we(we_rxbase), .ptr_we(we_rxptr),
    .wdata(wdata), .base_q(rxbase_q), .ptr_q(rxptr_q)
  );

  edma_gen_reg #(.ACC(ACC_RW), .RST(CTRL_RST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(we_ctrl), .wdata(wdata), .rd_word(ctrl_rd)
  );

  edma_gen_reg #(.ACC(ACC_RO), .RST(IDENT_VAL)) u_ident (
    .clk(clk), .rst_n(rst_n), .we(we_ident), .wdata(wdata), .rd_word(ident_rd)
  );

  edma_gen_reg #(.ACC(ACC_WO), .RST('0)) u_key (
    .clk(clk), .rst_n(rst_n), .we(we_key), .wdata(wdata), .rd_word(key_rd)
  );

  always_comb begin
    rdata = '0;
    unique case (idx)
      IW'(W_EVT):   rdata = evt_q;
      IW'(W_MASK):  rdata = mask_q;
      IW'(W_TXST):  rdata = txst_rd;
      IW'(W_RXST):  rdata = rxst_rd;
      IW'(W_CTRL):  rdata = ctrl_rd;
      IW'(W_IDENT): rdata = ident_rd;
      IW'(W_KEY):   rdata = key_rd;
      default:      rdata = '0;
    endcase
    for (int n = 0; n < NQ; n++) begin
      if (idx == IW'(W_TXBASE + n)) rdata = txbase_q[n];
      if (idx == IW'(W_TXPTR + n))  rdata = txptr_q[n];
      if (idx == IW'(W_RXBASE + n)) rdata = rxbase_q[n];
      if (idx == IW'(W_RXPTR + n))  rdata = rxptr_q[n];
    end
  end

  AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IW'(W_KEY)) |-> (rdata == '0)); // R8
  AST_KICK_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !((tx_kick != '0) && (rx_kick != '0))); // R4
endmodule

// File: tb/test_edma_csr.sv
module test_edma_csr;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [31:0]  evt_set = '0;
  logic [7:0]   tx_qhalt_set = '0;
  logic [7:0]   rx_qhalt_set = '0;
  logic         irq_tx, irq_rx, irq_err;
  logic [7:0]   tx_kick, rx_kick;
  logic [255:0] tx_ring_ptr, rx_ring_ptr;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_evt = '0;
  logic [31:0] m_mask = '0;

  always #2.5 clk = ~clk;

  edma_csr i_edma_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .evt_set(evt_set), .tx_qhalt_set(tx_qhalt_set), .rx_qhalt_set(rx_qhalt_set),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
    .tx_kick(tx_kick), .rx_kick(rx_kick),
    .tx_ring_ptr(tx_ring_ptr), .rx_ring_ptr(rx_ring_ptr)
  );

  task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, {224'd0, rdata}, {224'd0, exp});
  endtask

  task automatic pulse_evt(input logic [31:0] b);
    @(negedge clk);
    evt_set = b;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic chk_irq(input string req);
    check(req, {253'd0, irq_tx, irq_rx, irq_err},
          {253'd0, |(m_evt & m_mask & 32'h0000_00FF), |(m_evt & m_mask & 32'h0000_FF00),
           |(m_evt & m_mask & 32'hFFFF_0000)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog got hang exp finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 evt", 12'h000, 32'h0);
    rd_chk("R1 mask", 12'h004, 32'h0);
    rd_chk("R1 txst", 12'h008, 32'h0);
    rd_chk("R1 rxst", 12'h00C, 32'h0);
    rd_chk("R1 ctrl", 12'h010, 32'h0000_00C0);
    rd_chk("R1 ident", 12'h014, 32'h5EC0_0001);
    for (int n = 0; n < 8; n++) rd_chk("R1 txbase", 12'(12'h100 + 4 * n), 32'h0);
    check("R1 irq", {253'd0, irq_tx, irq_rx, irq_err}, 256'd0);
    check("R1 kicks", {240'd0, tx_kick, rx_kick}, 256'd0);
    check("R1 ptrs", tx_ring_ptr | rx_ring_ptr, 256'd0);

    // R2/R3 sweep every event bit against several masks
    for (int b = 0; b < 32; b++) begin
      pulse_evt(32'd1 << b);
      m_evt = 32'd1 << b;
      rd_chk("R2 evt set", 12'h000, m_evt);
      for (int k = 0; k < 4; k++) begin
        case (k)
          0: m_mask = 32'h0;
          1: m_mask = 32'd1 << b;
          2: m_mask = ~(32'd1 << b);
          default: m_mask = 32'hFFFF_FFFF;
        endcase
        wr(12'h004, m_mask);
        chk_irq("R3 irq groups");
      end
      wr(12'h000, 32'd1 << b);
      m_evt = '0;
      rd_chk("R2 w1c", 12'h000, 32'h0);
      chk_irq("R3 irq after clear");
    end

    // R2 multi-bit: clear only some
    pulse_evt(32'h8001_0101);
    wr(12'h000, 32'h0000_0100);
    m_evt = 32'h8001_0001;
    rd_chk("R2 partial clear", 12'h000, m_evt);
    chk_irq("R3 partial");
    // R2 set in same cycle as clear wins
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h000; wdata = 32'hFFFF_FFFF; evt_set = 32'h0000_0004;
    @(negedge clk);
    wr_en = 1'b0; evt_set = '0;
    m_evt = 32'h0000_0004;
    rd_chk("R2 set beats clear", 12'h000, m_evt);
    chk_irq("R3 after collision");
    wr(12'h000, 32'hFFFF_FFFF);
    m_evt = '0;

    // R4 transmit kicks per queue
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); tx_qhalt_set = 8'd1 << i;
      @(negedge clk); tx_qhalt_set = '0;
      rd_chk("R11 tx halt set", 12'h008, 32'h1 << (31 - i));
      wr(12'h008, 32'h1 << (31 - i));
      check("R4 tx kick", {248'd0, tx_kick}, {248'd0, 8'd1 << i});
      rd_chk("R4 tx stat cleared", 12'h008, 32'h0);
      @(negedge clk);
      check("R4 tx kick one cycle", {248'd0, tx_kick}, 256'd0);
    end
    wr(12'h008, 32'hFF00_0000);
    check("R4 tx kick all", {248'd0, tx_kick}, {248'd0, 8'hFF});

    // R5 receive kicks with edge qualification
    for (int i = 0; i < 8; i++) begin
      wr(12'h00C, 32'h1 << (23 - i));
      check("R5 rx kick clear bit", {248'd0, rx_kick}, {248'd0, 8'd1 << i});
      @(negedge clk);
      check("R5 rx kick one cycle", {248'd0, rx_kick}, 256'd0);
      @(negedge clk); rx_qhalt_set = 8'd1 << i;
      @(negedge clk); rx_qhalt_set = '0;
      rd_chk("R11 rx halt set", 12'h00C, 32'h1 << (23 - i));
      wr(12'h00C, 32'h1 << (23 - i));
      check("R5 rx no kick set bit", {248'd0, rx_kick}, 256'd0);
      rd_chk("R5 rx stat cleared", 12'h00C, 32'h0);
    end
    // R11 set beats clear on receive status, no kick for already-set bit
    @(negedge clk); rx_qhalt_set = 8'h04;
    @(negedge clk); rx_qhalt_set = '0;
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h00C; wdata = 32'h00FF_0000; rx_qhalt_set = 8'h04;
    @(negedge clk);
    wr_en = 1'b0; rx_qhalt_set = '0;
    check("R5 mixed kick", {248'd0, rx_kick}, {248'd0, 8'hFB});
    rd_chk("R11 rx set wins", 12'h00C, 32'h0020_0000);
    wr(12'h00C, 32'h0020_0000);

    // R6 ring bases and pointers
    for (int n = 0; n < 8; n++) begin
      logic [31:0] v;
      v = 32'h1000_0007 + 32'(n) * 32'h0001_0105;
      wr(12'(12'h100 + 4 * n), v);
      rd_chk("R6 tx base aligned", 12'(12'h100 + 4 * n), v & ~32'h7);
      rd_chk("R6 tx ptr copy", 12'(12'h120 + 4 * n), v & ~32'h7);
      check("R6 tx ptr port", {224'd0, tx_ring_ptr[n*32 +: 32]}, {224'd0, v & ~32'h7});
      wr(12'(12'h140 + 4 * n), ~v);
      rd_chk("R6 rx base aligned", 12'(12'h140 + 4 * n), ~v & ~32'h7);
      check("R6 rx ptr port", {224'd0, rx_ring_ptr[n*32 +: 32]}, {224'd0, ~v & ~32'h7});
      wr(12'(12'h160 + 4 * n), 32'hABCD_0003);
      rd_chk("R7 rx ptr raw", 12'(12'h160 + 4 * n), 32'hABCD_0003);
      rd_chk("R7 rx base kept", 12'(12'h140 + 4 * n), ~v & ~32'h7);
    end

    // R7/R8 generic access types
    wr(12'h010, 32'hA5A5_5A5B);
    rd_chk("R7 ctrl rw", 12'h010, 32'hA5A5_5A5B);
    wr(12'h014, 32'h0);
    rd_chk("R7 ident ro", 12'h014, 32'h5EC0_0001);
    wr(12'h018, 32'hDEAD_BEEF);
    rd_chk("R8 wo reads zero", 12'h018, 32'h0);

    // R9 unmapped
    wr(12'h01C, 32'hFFFF_FFFF);
    rd_chk("R9 unmapped 1c", 12'h01C, 32'h0);
    wr(12'h200, 32'hFFFF_FFFF);
    rd_chk("R9 unmapped 200", 12'h200, 32'h0);
    rd_chk("R9 ctrl untouched", 12'h010, 32'hA5A5_5A5B);
    rd_chk("R9 mask untouched", 12'h004, m_mask);

    // R10 low address bits ignored
    wr(12'h007, 32'h0000_1234);
    rd_chk("R10 mask via 0x005", 12'h005, 32'h0000_1234);
    wr(12'h013, 32'h0F0F_0F0F);
    rd_chk("R10 ctrl via 0x012", 12'h012, 32'h0F0F_0F0F);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule